// File: doc/BRIEF.md
# Clause Constant Cache Locker

This block pins a small window of shader constants for the duration of one ALU clause and turns window-relative constant indices into physical constant-buffer addresses. When a clause starts, it takes two configuration words. These describe two lock groups, each with its own buffer bank, lock mode and base cache line. It also samples the loop counter. It then requests a line fill for every cache line the configuration pins. Each line holds sixteen 128-bit constants. With two groups of up to two lines each, at most 64 constants are resident.

Once every fill has been accepted, the block raises `clause_ready`. From then on, each reference is resolved one cycle after it is presented. The result is a bank, a line and an entry, or an out-of-range error when the reference lands outside the pinned lines. A constant outside the pinned set cannot be reached in this clause. It needs a new clause start with a different lock configuration. The memory behind the cache and the ALU datapath are outside this block.

Top module: `cconst_lock`

## Requirements
- R1: After reset, `clause_ready`, `fill_valid` and `res_valid` are all low.
- R2: A clause start is accepted when `cfg_valid` is high and no fill sequence is running. The configuration fields are decoded as follows:
  - `cfg_word0[31:30]` is the group-0 mode.
  - `cfg_word0[3:0]` is the group-0 bank.
  - `cfg_word0[7:4]` is the group-1 bank.
  - `cfg_word0[8 +: LINE_W]` is the group-0 base line.
  - `cfg_word1[1:0]` is the group-1 mode.
  - `cfg_word1[2 +: LINE_W]` is the group-1 base line.
  - All other bits are ignored.
- R3: The mode codes are:
  - 0 pins no line.
  - 1 pins the base line only.
  - 2 pins the base line and the line after it.
  - 3 pins base+loop and base+loop+1, where loop is the captured loop counter.
  
  Fills are requested in this slot order: group 0 first line, group 0 second line, group 1 first line, group 1 second line. Slots that are not pinned are skipped.
- R4: While `fill_valid` is high and `fill_ready` is low, `fill_valid`, `fill_bank` and `fill_line` hold steady.
- R5: `clause_ready` rises only after every requested fill has been accepted, and it falls in the cycle after a new clause start is accepted.
- R6: The loop counter is captured once, when the clause start is accepted. Later changes to `loop_ctr` do not alter the lines of the running clause.
- R7: A reference presented with `ref_valid` yields `res_valid` on the next cycle. `ref_idx[5]` selects the group, `ref_idx[4]` selects the first (0) or second (1) line of that group, and `ref_idx[3:0]` is passed through as `res_entry`.
- R8: A reference raises `res_err`, with bank, line and entry driven to zero, in three cases:
  - the clause is not ready;
  - its group is in mode 0;
  - it targets the second line of a group in mode 1.
- R9: All line arithmetic wraps modulo 2^LINE_W.
- R10: A `cfg_valid` pulse that arrives while fills are still being requested is ignored. The running sequence and the clause configuration are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Clause start request |
| cfg_word0 | input | 32 | First clause control word (group-0 mode, both banks, group-0 base) |
| cfg_word1 | input | 32 | Second clause control word (group-1 mode and base) |
| loop_ctr | input | LOOP_W | Live loop counter, sampled at clause start |
| fill_valid | output | 1 | Line fill request valid |
| fill_ready | input | 1 | Line fill request accepted |
| fill_bank | output | 4 | Constant buffer of the requested line |
| fill_line | output | LINE_W | Cache-line number of the requested line |
| clause_ready | output | 1 | All pinned lines requested and accepted |
| ref_valid | input | 1 | Constant reference valid |
| ref_idx | input | 6 | Window-relative constant index |
| res_valid | output | 1 | Resolution result valid |
| res_err | output | 1 | Reference falls outside the pinned lines |
| res_bank | output | 4 | Resolved buffer bank |
| res_line | output | LINE_W | Resolved cache line |
| res_entry | output | 4 | Resolved entry within the line |

## Verification
The bench builds the block with LINE_W = 4 and LOOP_W = 6. The narrow line field lets base lines near 15 wrap past zero within a few values, which exercises R9 directly.

A loop counter wider than the line field also exercises truncation of the captured counter before it is added to the base. Small bank and base values keep every expected fill address and lookup result easy to restate in the bench from the mode encoding alone.

// File: rtl/cconst_pkg.sv
package cconst_pkg;

  localparam int BANK_W   = 4;
  localparam int ENTRY_W  = 4;
  localparam int IDX_W    = 6;
  localparam int GROUPS   = 2;
  localparam int W0_BASE_LSB = 8;
  localparam int W1_BASE_LSB = 2;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_ONE  = 2'd1,
    LK_TWO  = 2'd2,
    LK_LOOP = 2'd3
  } lock_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_READY = 2'd2
  } seq_state_e;

  // Whether a slot (first or second line of a group) is pinned by a mode.
  function automatic logic slot_needed(input logic [1:0] mode, input logic second);
    slot_needed = (mode != LK_NONE) && !(second && (mode == LK_ONE));
  endfunction

endpackage

// File: rtl/cconst_cfg_regs.sv
module cconst_cfg_regs
  import cconst_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int LOOP_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 load,
  input  logic [31:0]                          word0,
  input  logic [31:0]                          word1,
  input  logic [LOOP_W-1:0]                    loop_ctr,
  output logic [GROUPS-1:0][1:0]               mode,
  output logic [GROUPS-1:0][BANK_W-1:0]        bank,
  output logic [GROUPS-1:0][LINE_W-1:0]        eff_base
);

  logic [GROUPS-1:0][LINE_W-1:0] base_q;
  logic [LOOP_W-1:0]             loop_q;

  // Base plus captured loop offset, wrapping in the line width.
  function automatic logic [LINE_W-1:0] offset_base(
    input logic [LINE_W-1:0] base, input logic [1:0] m, input logic [LOOP_W-1:0] lp);
    offset_base = base + ((m == LK_LOOP) ? LINE_W'(lp) : '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      bank   <= '0;
      base_q <= '0;
      loop_q <= '0;
    end else if (load) begin
      mode[0]   <= word0[31:30];
      bank[0]   <= word0[3:0];
      bank[1]   <= word0[7:4];
      base_q[0] <= word0[W0_BASE_LSB +: LINE_W];
      mode[1]   <= word1[1:0];
      base_q[1] <= word1[W1_BASE_LSB +: LINE_W];
      loop_q    <= loop_ctr;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_base
    assign eff_base[g] = offset_base(base_q[g], mode[g], loop_q);
  end

endmodule

// File: rtl/cconst_fill_seq.sv
module cconst_fill_seq
  import cconst_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_valid,
  input  logic [GROUPS-1:0][1:0]        mode,
  input  logic [GROUPS-1:0][BANK_W-1:0] bank,
  input  logic [GROUPS-1:0][LINE_W-1:0] eff_base,
  input  logic                          fill_ready,
  output logic                          cfg_load,
  output logic                          fill_valid,
  output logic [BANK_W-1:0]             fill_bank,
  output logic [LINE_W-1:0]             fill_line,
  output logic                          fill_fire,
  output logic                          clause_ready
);

  seq_state_e state;
  logic [1:0] slot;
  logic       grp;
  logic       sec;
  logic       need;
  logic       advance;

  assign grp        = slot[1];
  assign sec        = slot[0];
  assign need       = slot_needed(mode[grp], sec);
  assign cfg_load   = cfg_valid && (state != ST_FILL);
  assign fill_valid = (state == ST_FILL) && need;
  assign fill_bank  = bank[grp];
  assign fill_line  = eff_base[grp] + LINE_W'(sec);
  assign fill_fire  = fill_valid && fill_ready;
  assign advance    = (state == ST_FILL) && (!need || fill_ready);
  assign clause_ready = (state == ST_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      slot  <= '0;
    end else if (cfg_load) begin
      state <= ST_FILL;
      slot  <= '0;
    end else if (advance) begin
      slot <= slot + 2'd1;
      if (slot == 2'd3) state <= ST_READY;
    end
  end

endmodule

// File: rtl/cconst_resolve.sv
module cconst_resolve
  import cconst_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ref_valid,
  input  logic [IDX_W-1:0]              ref_idx,
  input  logic                          clause_ready,
  input  logic [GROUPS-1:0][1:0]        mode,
  input  logic [GROUPS-1:0][BANK_W-1:0] bank,
  input  logic [GROUPS-1:0][LINE_W-1:0] eff_base,
  output logic                          res_valid,
  output logic                          res_err,
  output logic [BANK_W-1:0]             res_bank,
  output logic [LINE_W-1:0]             res_line,
  output logic [ENTRY_W-1:0]            res_entry
);

  logic grp;
  logic sec;
  logic hit;
  logic take;

  assign grp  = ref_idx[5];
  assign sec  = ref_idx[4];
  assign hit  = clause_ready && slot_needed(mode[grp], sec);
  assign take = ref_valid && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_bank  <= '0;
      res_line  <= '0;
      res_entry <= '0;
    end else begin
      res_valid <= ref_valid;
      res_err   <= ref_valid && !hit;
      res_bank  <= take ? bank[grp] : '0;
      res_line  <= take ? (eff_base[grp] + LINE_W'(sec)) : '0;
      res_entry <= take ? ref_idx[ENTRY_W-1:0] : '0;
    end
  end

endmodule

// File: rtl/cconst_lock.sv
module cconst_lock
  import cconst_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [31:0]       cfg_word0,
  input  logic [31:0]       cfg_word1,
  input  logic [LOOP_W-1:0] loop_ctr,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [3:0]        fill_bank,
  output logic [LINE_W-1:0] fill_line,
  output logic              clause_ready,
  input  logic              ref_valid,
  input  logic [5:0]        ref_idx,
  output logic              res_valid,
  output logic              res_err,
  output logic [3:0]        res_bank,
  output logic [LINE_W-1:0] res_line,
  output logic [3:0]        res_entry
);

  logic [GROUPS-1:0][1:0]        mode;
  logic [GROUPS-1:0][BANK_W-1:0] bank;
  logic [GROUPS-1:0][LINE_W-1:0] eff_base;
  logic                          cfg_load;
  logic                          fill_fire;
  logic                          unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_word0, cfg_word1, fill_fire};

  cconst_cfg_regs #(.LINE_W(LINE_W), .LOOP_W(LOOP_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .word0    (cfg_word0),
    .word1    (cfg_word1),
    .loop_ctr (loop_ctr),
    .mode     (mode),
    .bank     (bank),
    .eff_base (eff_base)
  );

  cconst_fill_seq #(.LINE_W(LINE_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .mode         (mode),
    .bank         (bank),
    .eff_base     (eff_base),
    .fill_ready   (fill_ready),
    .cfg_load     (cfg_load),
    .fill_valid   (fill_valid),
    .fill_bank    (fill_bank),
    .fill_line    (fill_line),
    .fill_fire    (fill_fire),
    .clause_ready (clause_ready)
  );

  cconst_resolve #(.LINE_W(LINE_W)) u_res (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_valid    (ref_valid),
    .ref_idx      (ref_idx),
    .clause_ready (clause_ready),
    .mode         (mode),
    .bank         (bank),
    .eff_base     (eff_base),
    .res_valid    (res_valid),
    .res_err      (res_err),
    .res_bank     (res_bank),
    .res_line     (res_line),
    .res_entry    (res_entry)
  );

endmodule

// File: rtl/cconst_lock_chk.sv
module cconst_lock_chk #(
  parameter int LINE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              fill_valid,
  input logic              fill_ready,
  input logic [3:0]        fill_bank,
  input logic [LINE_W-1:0] fill_line,
  input logic              clause_ready,
  input logic              ref_valid,
  input logic [5:0]        ref_idx,
  input logic              res_valid,
  input logic              res_err,
  input logic [3:0]        res_bank,
  input logic [LINE_W-1:0] res_line,
  input logic [3:0]        res_entry
);

  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_ready |=> fill_valid && $stable(fill_bank) && $stable(fill_line)); // R4

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clause_ready |-> !fill_valid); // R5

  AST_LOAD_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !clause_ready); // R5

  AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> res_valid); // R7

  AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> !res_valid); // R7

  AST_ENTRY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> (res_err || res_entry == $past(ref_idx[3:0]))); // R7

  AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_err |-> (res_bank == 4'd0 && res_line == '0 && res_entry == 4'd0)); // R8

  AST_NOT_READY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !clause_ready |=> res_err); // R8

endmodule

bind cconst_lock cconst_lock_chk #(.LINE_W(LINE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_load     (cfg_load),
  .fill_valid   (fill_valid),
  .fill_ready   (fill_ready),
  .fill_bank    (fill_bank),
  .fill_line    (fill_line),
  .clause_ready (clause_ready),
  .ref_valid    (ref_valid),
  .ref_idx      (ref_idx),
  .res_valid    (res_valid),
  .res_err      (res_err),
  .res_bank     (res_bank),
  .res_line     (res_line),
  .res_entry    (res_entry)
);

// File: tb/cconst_lock_bench.sv
module cconst_lock_bench;

  localparam int LW  = 4;
  localparam int LPW = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_valid = 1'b0;
  logic [31:0]    cfg_word0 = '0;
  logic [31:0]    cfg_word1 = '0;
  logic [LPW-1:0] loop_ctr = '0;
  logic           fill_valid;
  logic           fill_ready = 1'b0;
  logic [3:0]     fill_bank;
  logic [LW-1:0]  fill_line;
  logic           clause_ready;
  logic           ref_valid = 1'b0;
  logic [5:0]     ref_idx = '0;
  logic           res_valid;
  logic           res_err;
  logic [3:0]     res_bank;
  logic [LW-1:0]  res_line;
  logic [3:0]     res_entry;

  int checks = 0;
  int errors = 0;

  // Expected and observed fill lists.
  int exp_n, got_n;
  int exp_bank [4];
  int exp_line [4];
  int got_bank [4];
  int got_line [4];
  logic [31:0] cur_w0, cur_w1;
  int cur_lc;

  always #5 clk = ~clk;

  cconst_lock #(.LINE_W(LW), .LOOP_W(LPW)) u_cconst_lock (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word0(cfg_word0),
    .cfg_word1(cfg_word1), .loop_ctr(loop_ctr), .fill_valid(fill_valid),
    .fill_ready(fill_ready), .fill_bank(fill_bank), .fill_line(fill_line),
    .clause_ready(clause_ready), .ref_valid(ref_valid), .ref_idx(ref_idx),
    .res_valid(res_valid), .res_err(res_err), .res_bank(res_bank),
    .res_line(res_line), .res_entry(res_entry)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_w0(int m, int b0, int b1, int base);
    return (32'(m) << 30) | (32'(base & 15) << 8) | (32'(b1 & 15) << 4) | 32'(b0 & 15);
  endfunction

  function automatic logic [31:0] mk_w1(int m, int base);
    return (32'(base & 15) << 2) | 32'(m & 3);
  endfunction

  // Pinned-slot rule and line address, restated from R3 and R9.
  function automatic int slot_mode(int g);
    return g ? int'(cur_w1[1:0]) : int'(cur_w0[31:30]);
  endfunction
  function automatic bit slot_on(int g, int sec);
    int m = slot_mode(g);
    return (m != 0) && !(sec == 1 && m == 1);
  endfunction
  function automatic int slot_line(int g, int sec);
    int m = slot_mode(g);
    int b = g ? int'(cur_w1[5:2]) : int'(cur_w0[11:8]);
    return (b + ((m == 3) ? (cur_lc % 16) : 0) + sec) % 16;
  endfunction
  function automatic int slot_bank(int g);
    return g ? int'(cur_w0[7:4]) : int'(cur_w0[3:0]);
  endfunction

  task automatic build_exp(input logic [31:0] w0, input logic [31:0] w1, input int lc);
    cur_w0 = w0; cur_w1 = w1; cur_lc = lc;
    exp_n = 0;
    for (int s = 0; s < 4; s++) begin
      if (slot_on(s / 2, s % 2)) begin
        exp_bank[exp_n] = slot_bank(s / 2);
        exp_line[exp_n] = slot_line(s / 2, s % 2);
        exp_n++;
      end
    end
  endtask

  // Runs the fill handshake until clause_ready, recording accepted fills.
  task automatic collect(input int stall);
    bit held = 0;
    int pb = 0, pl = 0;
    got_n = 0;
    for (int c = 0; c < 60; c++) begin
      fill_ready = (stall == 0) ? 1'b1 : ((c % stall) != 0);
      #1;
      if (held) begin
        chk(fill_valid && int'(fill_bank) == pb && int'(fill_line) == pl, "R4", "held fill",
            int'(fill_line), pl);
      end
      if (clause_ready) break;
      held = fill_valid && !fill_ready;
      pb = int'(fill_bank); pl = int'(fill_line);
      if (fill_valid && fill_ready && got_n < 4) begin
        got_bank[got_n] = int'(fill_bank);
        got_line[got_n] = int'(fill_line);
        got_n++;
      end
      @(negedge clk);
    end
    fill_ready = 1'b0;
    chk(clause_ready, "R5", "clause_ready after fills", int'(clause_ready), 1);
  endtask

  task automatic compare_fills(input string req);
    chk(got_n == exp_n, req, "fill count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_bank[i] == exp_bank[i], req, "fill bank", got_bank[i], exp_bank[i]);
      chk(got_line[i] == exp_line[i], req, "fill line", got_line[i], exp_line[i]);
    end
  endtask

  task automatic run_clause(input logic [31:0] w0, input logic [31:0] w1, input int lc,
                            input int stall, input string req);
    build_exp(w0, w1, lc);
    @(negedge clk);
    cfg_word0 = w0; cfg_word1 = w1; loop_ctr = LPW'(lc); cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_word0 = ~w0; cfg_word1 = ~w1; loop_ctr = ~LPW'(lc);
    #1;
    chk(!clause_ready, "R5", "ready low after start", int'(clause_ready), 0);
    collect(stall);
    compare_fills(req);
  endtask

  task automatic check_ref(input int idx, input bit force_err, input string req);
    int g = idx / 32;
    int sec = (idx / 16) % 2;
    bit e = force_err || !slot_on(g, sec);
    @(negedge clk);
    ref_valid = 1'b1; ref_idx = 6'(idx);
    @(negedge clk);
    ref_valid = 1'b0;
    #1;
    chk(res_valid, req, "res_valid", int'(res_valid), 1);
    chk(res_err == e, req, "res_err", int'(res_err), int'(e));
    if (e) begin
      chk(res_bank == 0 && res_line == 0 && res_entry == 0, req, "zero fields on error",
          int'(res_line), 0);
    end else begin
      chk(int'(res_bank) == slot_bank(g), req, "res_bank", int'(res_bank), slot_bank(g));
      chk(int'(res_line) == slot_line(g, sec), req, "res_line", int'(res_line), slot_line(g, sec));
      chk(int'(res_entry) == idx % 16, req, "res_entry", int'(res_entry), idx % 16);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(!clause_ready, "R1", "clause_ready at reset", int'(clause_ready), 0);
    chk(!fill_valid, "R1", "fill_valid at reset", int'(fill_valid), 0);
    chk(!res_valid, "R1", "res_valid at reset", int'(res_valid), 0);
  endtask

  task automatic t_before_clause();
    check_ref(6'h05, 1'b1, "R8");
  endtask

  task automatic t_two_lines_both();
    run_clause(mk_w0(2, 3, 9, 5), mk_w1(2, 12), 0, 0, "R3");
    check_ref(6'h13, 1'b0, "R7");
    check_ref(6'h3F, 1'b0, "R7");
    check_ref(6'h20, 1'b0, "R2");
  endtask

  task automatic t_one_line_stall();
    run_clause(mk_w0(1, 7, 2, 9) | 32'h0003_0000, mk_w1(0, 4) | 32'hF000_0000, 0, 2, "R2");
    check_ref(6'h07, 1'b0, "R7");
    check_ref(6'h10, 1'b0, "R8");
    check_ref(6'h25, 1'b0, "R8");
  endtask

  task automatic t_loop_wrap();
    run_clause(mk_w0(3, 1, 6, 14), mk_w1(3, 15), 6'h23, 3, "R9");
    check_ref(6'h11, 1'b0, "R6");
    check_ref(6'h32, 1'b0, "R9");
  endtask

  task automatic t_cfg_during_fill();
    build_exp(mk_w0(2, 4, 5, 2), mk_w1(1, 8), 0);
    @(negedge clk);
    cfg_word0 = cur_w0; cfg_word1 = cur_w1; loop_ctr = '0; cfg_valid = 1'b1;
    fill_ready = 1'b0;
    @(negedge clk);
    cfg_valid = 1'b0;
    @(negedge clk);
    cfg_word0 = mk_w0(3, 11, 12, 7); cfg_word1 = mk_w1(2, 1); loop_ctr = 6'h09;
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    collect(0);
    compare_fills("R10");
    check_ref(6'h1A, 1'b0, "R10");
    check_ref(6'h30, 1'b0, "R10");
  endtask

  task automatic t_all_off();
    run_clause(mk_w0(0, 3, 3, 3), mk_w1(0, 3), 0, 0, "R3");
    check_ref(6'h00, 1'b0, "R8");
    check_ref(6'h2C, 1'b0, "R8");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "WATCHDOG", "run timed out", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_before_clause();
    t_two_lines_both();
    t_one_line_stall();
    t_loop_wrap();
    t_cfg_during_fill();
    t_all_off();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule